// File: doc/BRIEF.md
# Signed High-Word Multiply-Accumulate Unit

This datapath unit multiplies two signed two's-complement operands of equal width (32 bits by default) and returns only the upper half of the double-width product. Two further operations use a third operand, the accumulator, which is aligned to the high word. One adds it to the product. The other subtracts the product from it. Any of the three operations can round to nearest instead of truncating. Rounding adds a half-LSB constant to the double-width intermediate before the upper half is taken.

The unit has a fixed two-stage pipeline. Stage one registers the full signed product together with the control fields. Stage two registers the combine, the rounding and the high-word extraction. It accepts one operation per cycle without stalls, and a valid strobe travels alongside each operation. The unit keeps no flags or other status.

Top module: `hwmac_top`

## Requirements
- R1: Operands `in_a` and `in_b` are signed two's complement. With `in_op` = 2'b00 (multiply), the result is bits [63:32] of the 64-bit signed product.
- R2: With `in_op` = 2'b01 (accumulate), the result is bits [63:32] of (`in_acc` shifted left by 32) + product.
- R3: With `in_op` = 2'b10 (reverse subtract), the result is bits [63:32] of (`in_acc` shifted left by 32) − product.
- R4: With `in_round` = 1, 0x80000000 is added to the 64-bit intermediate before bits [63:32] are taken. With `in_round` = 0, the low 32 bits are dropped.
- R5: All 64-bit arithmetic wraps modulo 2^64 and never saturates. For example, 0x80000000 × 0x80000000 in multiply mode gives 0x40000000.
- R6: The reserved code `in_op` = 2'b11 gives the same result as multiply.
- R7: In multiply mode (and in the reserved mode), the value of `in_acc` has no effect on the result.
- R8: `out_valid` equals `in_valid` from exactly two rising edges earlier, with `out_result` valid in the same cycle. A new operation is accepted on every edge.
- R9: Reset is synchronous and active low (`rst_n` = 0). It clears both pipeline valid bits, so `out_valid` is 0 after any edge taken in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_op | input | 2 | 00 multiply, 01 accumulate, 10 reverse subtract, 11 treated as multiply |
| in_round | input | 1 | 1 = round to nearest, 0 = truncate |
| in_a | input | 32 | Signed multiplicand |
| in_b | input | 32 | Signed multiplier |
| in_acc | input | 32 | Signed high-word accumulator operand |
| out_valid | output | 1 | Result present on `out_result` |
| out_result | output | 32 | Upper word of the selected computation |

## Verification
Every result is due exactly two rising edges after its inputs are presented, so an input driven on one falling edge appears at the outputs on the second falling edge that follows. The bench drives inputs and samples outputs on falling edges. It holds the expected value and valid bit of each operation in a two-deep shift register and compares the oldest entry on every falling edge. This arrangement also tests back-to-back issue and the idle cycles between operations. During a reset applied mid-stream, the bench checks that `out_valid` is 0 on the following falling edges, and it drops the expectations that were in flight.

// File: rtl/hwmac_pkg.sv
// Package: shared operation encoding for the high-word multiply-accumulate unit.
// Assumes a 2-bit operation select; the code 2'b11 is reserved and acts as multiply.
package hwmac_pkg;
    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_ACC  = 2'b01,
        OP_RSUB = 2'b10,
        OP_RSVD = 2'b11
    } hwmac_op_e;
endpackage

// File: rtl/hwmac_prod_stage.sv
// Stage 1: forms the full signed double-width product and registers it with the
// control fields and the accumulator operand.
// Assumes operands are two's complement; only the valid bit is reset.
module hwmac_prod_stage
    import hwmac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  hwmac_op_e         in_op,
    input  logic              in_round,
    input  logic [W-1:0]      in_a,
    input  logic [W-1:0]      in_b,
    input  logic [W-1:0]      in_acc,
    output logic              s1_valid,
    output hwmac_op_e         s1_op,
    output logic              s1_round,
    output logic [2*W-1:0]    s1_prod,
    output logic [W-1:0]      s1_acc
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic        [PW-1:0] prod_d;

    // Sign-extend both operands and multiply at full width (wraps mod 2^PW).
    always_comb begin
        a_ext  = $signed({{W{in_a[W-1]}}, in_a});
        b_ext  = $signed({{W{in_b[W-1]}}, in_b});
        prod_d = a_ext * b_ext;
    end

    // Valid bit with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
    end

    // Datapath registers, loaded every cycle.
    always_ff @(posedge clk) begin
        s1_op    <= in_op;
        s1_round <= in_round;
        s1_prod  <= prod_d;
        s1_acc   <= in_acc;
    end
endmodule

// File: rtl/hwmac_combine_stage.sv
// Stage 2: applies the high-word aligned accumulate or reverse subtract, injects
// the rounding constant, and registers the upper word.
// Assumes modular arithmetic at double width with no saturation.
module hwmac_combine_stage
    import hwmac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  hwmac_op_e         s1_op,
    input  logic              s1_round,
    input  logic [2*W-1:0]    s1_prod,
    input  logic [W-1:0]      s1_acc,
    output logic              out_valid,
    output logic [W-1:0]      out_result
);
    localparam int PW = 2 * W;
    localparam logic [PW-1:0] HALF_LSB = PW'(1) << (W - 1);

    logic [PW-1:0] acc_hi;
    logic [PW-1:0] mixed;
    logic [PW-1:0] rounded;

    // Select the double-width intermediate for the requested operation.
    always_comb begin
        acc_hi = {s1_acc, {W{1'b0}}};
        case (s1_op)
            OP_ACC:  mixed = acc_hi + s1_prod;
            OP_RSUB: mixed = acc_hi - s1_prod;
            default: mixed = s1_prod;
        endcase
        rounded = s1_round ? (mixed + HALF_LSB) : mixed;
    end

    // Output valid with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s1_valid;
    end

    // Register the upper word of the intermediate.
    always_ff @(posedge clk) begin
        out_result <= rounded[PW-1:W];
    end
endmodule

// File: rtl/hwmac_top.sv
// Top: two-stage signed high-word multiply / accumulate / reverse subtract.
// Assumes one operation per cycle and a fixed latency of two edges.
module hwmac_top
    import hwmac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    in_op,
    input  logic          in_round,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    input  logic [W-1:0]  in_acc,
    output logic          out_valid,
    output logic [W-1:0]  out_result
);
    localparam int PW = 2 * W;

    logic           s1_valid;
    hwmac_op_e      s1_op;
    logic           s1_round;
    logic [PW-1:0]  s1_prod;
    logic [W-1:0]   s1_acc;

    hwmac_prod_stage #(.W(W)) u_prod (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_op    (hwmac_op_e'(in_op)),
        .in_round (in_round),
        .in_a     (in_a),
        .in_b     (in_b),
        .in_acc   (in_acc),
        .s1_valid (s1_valid),
        .s1_op    (s1_op),
        .s1_round (s1_round),
        .s1_prod  (s1_prod),
        .s1_acc   (s1_acc)
    );

    hwmac_combine_stage #(.W(W)) u_comb (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_op      (s1_op),
        .s1_round   (s1_round),
        .s1_prod    (s1_prod),
        .s1_acc     (s1_acc),
        .out_valid  (out_valid),
        .out_result (out_result)
    );
endmodule

// File: rtl/hwmac_checker.sv
// Checker: timing and arithmetic properties of hwmac_top, observed at its ports.
// Assumes the synchronous active-low reset; checks start two edges after release.
module hwmac_checker #(
    parameter int W = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    in_op,
    input logic          in_round,
    input logic [W-1:0]  in_a,
    input logic [W-1:0]  in_b,
    input logic [W-1:0]  in_acc,
    input logic          out_valid,
    input logic [W-1:0]  out_result
);
    localparam int PW = 2 * W;

    logic [1:0] since_rst;

    // Count edges since reset release, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    function automatic logic [W-1:0] model(input logic [1:0] op, input logic rnd,
                                           input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [W-1:0] acc);
        logic signed [PW-1:0] p;
        logic [PW-1:0] t;
        p = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
        if (op == 2'b01)      t = {acc, {W{1'b0}}} + p;
        else if (op == 2'b10) t = {acc, {W{1'b0}}} - p;
        else                  t = p;
        if (rnd) t = t + (PW'(1) << (W - 1));
        return t[PW-1:W];
    endfunction

    // R8
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2) |-> (out_valid == $past(in_valid, 2)));

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R1
    result_model_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2 && out_valid) |->
        (out_result == model($past(in_op, 2), $past(in_round, 2), $past(in_a, 2),
                             $past(in_b, 2), $past(in_acc, 2))));

    // R7
    acc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2 && out_valid && $past(in_op, 2) != 2'b01 && $past(in_op, 2) != 2'b10) |->
        (out_result == model(2'b00, $past(in_round, 2), $past(in_a, 2), $past(in_b, 2), '0)));

    // R8
    valid_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(out_valid));
endmodule

bind hwmac_top hwmac_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_round   (in_round),
    .in_a       (in_a),
    .in_b       (in_b),
    .in_acc     (in_acc),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/hwmac_top_tb.sv
// Bench: corner sweep plus random stream, reference computed at 64 bits.
module hwmac_top_tb;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [1:0]    in_op;
    logic          in_round;
    logic [W-1:0]  in_a, in_b, in_acc;
    logic          out_valid;
    logic [W-1:0]  out_result;

    int tests = 0;
    int fails = 0;

    logic          v1 = 1'b0, v2 = 1'b0;
    logic [W-1:0]  e1 = '0, e2 = '0;
    string         t1 = "", t2 = "";

    always #2 clk = ~clk;

    hwmac_top #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_round(in_round), .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [31:0] ref_calc(input logic [1:0] op, input logic rnd,
                                             input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] acc);
        longint p;
        longint t;
        p = longint'($signed(a)) * longint'($signed(b));
        case (op)
            2'b01:   t = (longint'($signed(acc)) <<< 32) + p;
            2'b10:   t = (longint'($signed(acc)) <<< 32) - p;
            default: t = p;
        endcase
        if (rnd) t = t + 64'sh8000_0000;
        return t[63:32];
    endfunction

    function automatic string tag_of(input logic [1:0] op, input logic rnd);
        string s;
        case (op)
            2'b00: s = "R1/R7";
            2'b01: s = "R2";
            2'b10: s = "R3";
            default: s = "R6";
        endcase
        if (rnd) s = {s, "+R4"};
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One falling-edge step: compare the result due now, then issue a new input.
    task automatic step(input logic v, input logic [1:0] op, input logic rnd,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc);
        @(negedge clk);
        check({"R8 valid ", t2}, {31'd0, out_valid}, {31'd0, v2});
        if (v2) check(t2, out_result, e2);
        v2 = v1; e2 = e1; t2 = t1;
        in_valid = v; in_op = op; in_round = rnd; in_a = a; in_b = b; in_acc = acc;
        v1 = v; e1 = ref_calc(op, rnd, a, b, acc); t1 = tag_of(op, rnd);
    endtask

    logic [31:0] corners [6] = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                 32'h8000_0000, 32'h1, 32'h0001_8000};

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; in_valid = 1'b1; in_op = '0; in_round = 1'b0;
        in_a = '0; in_b = '0; in_acc = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset valid", {31'd0, out_valid}, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R5: wrap example, checked directly
        step(1'b1, 2'b00, 1'b0, 32'h8000_0000, 32'h8000_0000, 32'h1234_5678);
        step(1'b0, 2'b00, 1'b0, 0, 0, 0);
        step(1'b0, 2'b00, 1'b0, 0, 0, 0);
        // the previous step compared it against ref; add an explicit R5 value check
        check("R5 wrap reference", ref_calc(2'b00, 1'b0, 32'h8000_0000, 32'h8000_0000, 0),
              32'h4000_0000);

        // R7: same operands, different accumulators, multiply mode
        step(1'b1, 2'b00, 1'b1, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0);
        step(1'b1, 2'b00, 1'b1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hDEAD_BEEF);
        step(1'b1, 2'b11, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h5555_5555);

        // Corner sweep over every mode and rounding setting.
        for (int op = 0; op < 4; op++)
            for (int r = 0; r < 2; r++)
                for (int i = 0; i < 6; i++)
                    for (int j = 0; j < 6; j++)
                        for (int k = 0; k < 6; k++)
                            step(1'b1, op[1:0], r[0], corners[i], corners[j], corners[k]);

        // Random stream with idle gaps.
        for (int n = 0; n < 3000; n++)
            step(($urandom % 4) != 0, 2'($urandom), 1'($urandom),
                 $urandom, $urandom, $urandom);

        // R9: reset mid-stream drops in-flight operations.
        step(1'b1, 2'b01, 1'b0, 32'h3, 32'h4, 32'h5);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R9 mid reset valid", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check("R9 mid reset valid 2", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1; v1 = 1'b0; v2 = 1'b0;
        step(1'b1, 2'b10, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000);
        step(1'b0, 2'b00, 1'b0, 0, 0, 0);
        step(1'b0, 2'b00, 1'b0, 0, 0, 0);
        step(1'b0, 2'b00, 1'b0, 0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule